// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host processor sequential access to a small on-chip packet memory through one data port. The host first programs a 16-bit starting address and a 16-bit byte count, each as two separate byte-wide register writes. It then issues a remote read or remote write command and streams data through the port. Every port access moves one, two or four bytes. After each access the engine steps the address, folds it back to the ring start when it lands on the ring stop address, and counts down the bytes that remain. It raises a completion status bit when the count runs out, and that bit can drive the interrupt line.

The memory holds a 32-byte identification area at the bottom of the address space and a packet area starting at a parameterised base. Each byte lane of a multi-byte access is checked against these two regions on its own. A lane outside both regions reads as all ones, and writes to it are lost. A register read port returns the command byte, the status byte, the live address and count, the data-width configuration and the interrupt mask.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the status register (offset 0x7) reads 0x80, the command register (offset 0x0) reads 0x01, the address, the count, the configuration and the mask read 0, and `irq` is low.
- R2: Writes to offset 0x8 or 0x9 replace only the low or the high byte of the address. Writes to offset 0xA or 0xB replace only the low or the high byte of the count.
- R3: A port access moves 4 bytes when `dp_long` is high. Otherwise it moves 2 bytes when bit 0 of the configuration register (offset 0xE) is 1, and 1 byte when that bit is 0.
- R4: Each accepted access adds its size to the address. If the sum equals `ring_stop`, the address becomes `ring_start` instead.
- R5: If the count is no greater than the access size, the count becomes 0 and status bit 6 is set. Otherwise the count drops by the access size.
- R6: A port write while the count is 0 leaves the memory, the address and the count unchanged.
- R7: A command write with bit 0 clear clears status bit 7. If bit 3 or bit 4 of that write is also set while the count is 0, status bit 6 is set at once. A command with bit 0 set does neither.
- R8: A byte lane whose address lies neither below 32 nor inside [PMEM_BASE, PMEM_BASE+PMEM_BYTES) reads 0xFF, and writes to that lane are dropped. The address and the count still advance.
- R9: Two-byte and four-byte accesses clear the low address bit before use. Byte 0 sits in bits 7:0 (little-endian). Lanes beyond the access size read as 0.
- R10: `irq` is high exactly when status AND mask AND 0x7F is nonzero. Writing to offset 0x7 clears the status bits 6..0 that are written as 1. Bit 7 cannot be cleared this way.
- R11: `reg_rdata` returns command, status, address low/high, count low/high, configuration and mask at offsets 0x0, 0x7, 0x8, 0x9, 0xA, 0xB, 0xE and 0xF. All other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| dp_rd | input | 1 | Data port read strobe |
| dp_wr | input | 1 | Data port write strobe (wins over a read in the same cycle) |
| dp_long | input | 1 | Data port access is four bytes wide |
| dp_wdata | input | 32 | Data port write data, little-endian lanes |
| dp_rdata | output | 32 | Data at the current address for the current access size |
| ring_start | input | 16 | Ring start byte address, target of the wrap |
| ring_stop | input | 16 | Ring stop byte address, wrap trigger |
| dma_done | output | 1 | Status bit 6, remote transfer complete |
| irq | output | 1 | Interrupt request |

## Verification
If the address register holds a wrong value, the next port read returns bytes from the wrong place. A readback at offsets 0x8/0x9 shows the fault one access later. If the count is wrong, the completion bit rises one or more accesses too early or too late, and the write-ignore gate opens or closes at the wrong point. Walking a transfer across the ring stop with mixed access sizes, then reading the same bytes back with other sizes, places any error in the wrap, the alignment or the byte-lane order at a single known access.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int CNT_W     = 16;
    localparam int REG_OFF_W = 4;
    localparam int LANES     = 4;
    localparam int DATA_W    = LANES * BYTE_W;
    localparam int SIZE_W    = $clog2(LANES) + 1;

    localparam logic [REG_OFF_W-1:0] OFF_CMD     = 4'h0;
    localparam logic [REG_OFF_W-1:0] OFF_ISR     = 4'h7;
    localparam logic [REG_OFF_W-1:0] OFF_ADDR_LO = 4'h8;
    localparam logic [REG_OFF_W-1:0] OFF_ADDR_HI = 4'h9;
    localparam logic [REG_OFF_W-1:0] OFF_CNT_LO  = 4'hA;
    localparam logic [REG_OFF_W-1:0] OFF_CNT_HI  = 4'hB;
    localparam logic [REG_OFF_W-1:0] OFF_DCFG    = 4'hE;
    localparam logic [REG_OFF_W-1:0] OFF_IMR     = 4'hF;

    localparam int CMD_BIT_HALT  = 0;
    localparam int CMD_BIT_RREAD = 3;
    localparam int CMD_BIT_RWRIT = 4;
    localparam int ISR_BIT_DONE  = 6;
    localparam int ISR_BIT_RST   = 7;
    localparam int DCFG_BIT_WIDE = 0;

    localparam logic [BYTE_W-1:0] ISR_IRQ_MASK  = 8'h7F;
    localparam logic [BYTE_W-1:0] ISR_RESET_VAL = 8'h80;
    localparam logic [BYTE_W-1:0] CMD_RESET_VAL = 8'h01;

    typedef enum logic [1:0] {
        XS_BYTE = 2'd0,
        XS_WORD = 2'd1,
        XS_LONG = 2'd2
    } xfer_size_e;

    typedef struct packed {
        logic       fire;
        logic       is_wr;
        xfer_size_e sz;
    } port_req_t;

    function automatic logic [SIZE_W-1:0] xfer_bytes(xfer_size_e s);
        case (s)
            XS_WORD: return SIZE_W'(2);
            XS_LONG: return SIZE_W'(4);
            default: return SIZE_W'(1);
        endcase
    endfunction

    function automatic xfer_size_e pick_size(logic long_acc, logic wide_cfg);
        if (long_acc)      return XS_LONG;
        else if (wide_cfg) return XS_WORD;
        else               return XS_BYTE;
    endfunction

endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
    import rdma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_OFF_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0]    reg_wdata,
    input  logic                 cnt_zero,
    input  logic                 xfer_done,
    output logic [BYTE_W-1:0]    cmd_q,
    output logic [BYTE_W-1:0]    isr_q,
    output logic [BYTE_W-1:0]    imr_q,
    output logic [BYTE_W-1:0]    dcfg_q,
    output logic                 irq
);

    logic              cmd_wr;
    logic              cmd_go;
    logic [BYTE_W-1:0] isr_n;

    assign cmd_wr = reg_wr && (reg_addr == OFF_CMD);
    assign cmd_go = cmd_wr && !reg_wdata[CMD_BIT_HALT];

    always_comb begin
        isr_n = isr_q;
        if (reg_wr && reg_addr == OFF_ISR) begin
            isr_n = isr_n & ~(reg_wdata & ISR_IRQ_MASK);
        end
        if (cmd_go) begin
            isr_n[ISR_BIT_RST] = 1'b0;
            if ((reg_wdata[CMD_BIT_RREAD] || reg_wdata[CMD_BIT_RWRIT]) && cnt_zero) begin
                isr_n[ISR_BIT_DONE] = 1'b1;
            end
        end
        if (xfer_done) begin
            isr_n[ISR_BIT_DONE] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_RESET_VAL;
            isr_q  <= ISR_RESET_VAL;
            imr_q  <= '0;
            dcfg_q <= '0;
        end else begin
            isr_q <= isr_n;
            if (cmd_wr) cmd_q <= reg_wdata;
            if (reg_wr && reg_addr == OFF_IMR)  imr_q  <= reg_wdata;
            if (reg_wr && reg_addr == OFF_DCFG) dcfg_q <= reg_wdata;
        end
    end

    assign irq = |(isr_q & imr_q & ISR_IRQ_MASK);

    // R5: a finished transfer always leaves the done bit set
    p_done_sets_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> isr_q[ISR_BIT_DONE]);

    // R7: zero-length remote command completes at once
    p_zero_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && (reg_wdata[CMD_BIT_RREAD] || reg_wdata[CMD_BIT_RWRIT]) && cnt_zero)
        |=> isr_q[ISR_BIT_DONE]);

    // R10: the reset bit survives everything but a running command
    p_rst_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (isr_q[ISR_BIT_RST] && !cmd_go) |=> isr_q[ISR_BIT_RST]);

    // R10: a zero mask keeps the line quiet
    p_mask_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (imr_q == '0) |-> !irq);

endmodule

// File: rtl/rdma_addr_ctr.sv
module rdma_addr_ctr
    import rdma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_OFF_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0]    reg_wdata,
    input  port_req_t            req,
    input  logic [ADDR_W-1:0]    ring_start,
    input  logic [ADDR_W-1:0]    ring_stop,
    output logic [ADDR_W-1:0]    addr_q,
    output logic [CNT_W-1:0]     cnt_q,
    output logic                 take,
    output logic                 xfer_done
);

    logic [SIZE_W-1:0] nbytes;
    logic [ADDR_W-1:0] addr_sum;
    logic [ADDR_W-1:0] addr_next;
    logic [CNT_W-1:0]  cnt_next;

    assign nbytes    = xfer_bytes(req.sz);
    assign take      = req.fire && (!req.is_wr || (cnt_q != '0));
    assign addr_sum  = addr_q + ADDR_W'(nbytes);
    assign addr_next = (addr_sum == ring_stop) ? ring_start : addr_sum;
    assign xfer_done = take && (cnt_q <= CNT_W'(nbytes));
    assign cnt_next  = xfer_done ? '0 : (cnt_q - CNT_W'(nbytes));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    OFF_ADDR_LO: addr_q[BYTE_W-1:0]      <= reg_wdata;
                    OFF_ADDR_HI: addr_q[ADDR_W-1:BYTE_W] <= reg_wdata[ADDR_W-BYTE_W-1:0];
                    OFF_CNT_LO:  cnt_q[BYTE_W-1:0]       <= reg_wdata;
                    OFF_CNT_HI:  cnt_q[CNT_W-1:BYTE_W]   <= reg_wdata[CNT_W-BYTE_W-1:0];
                    default: ;
                endcase
            end
            if (take) begin
                addr_q <= addr_next;
                cnt_q  <= cnt_next;
            end
        end
    end

    // R4: after any accepted access the address never rests on the stop address
    p_no_stop_r4: assert property (@(posedge clk) disable iff (rst)
        (take && (ring_start != ring_stop)) |=> (addr_q != $past(ring_stop)));

    // R6: writes with nothing left to move change neither pointer nor count
    p_wr_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (req.fire && req.is_wr && (cnt_q == '0) && !reg_wr)
        |=> ($stable(addr_q) && (cnt_q == '0)));

    // R5: the count only shrinks under port traffic
    p_cnt_shrinks_r5: assert property (@(posedge clk) disable iff (rst)
        (take && !reg_wr) |=> ((cnt_q < $past(cnt_q)) || (cnt_q == '0)));

endmodule

// File: rtl/rdma_lane_mem.sv
module rdma_lane_mem
    import rdma_pkg::*;
#(
    parameter int PROM_BYTES = 32,
    parameter int PMEM_BASE  = 256,
    parameter int PMEM_BYTES = 512
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [SIZE_W-1:0] nbytes,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int MEM_BYTES = PROM_BYTES + PMEM_BYTES;
    localparam int IDX_W     = $clog2(MEM_BYTES);
    localparam int PMEM_END  = PMEM_BASE + PMEM_BYTES;

    logic [BYTE_W-1:0] mem_a [MEM_BYTES];

    logic [ADDR_W-1:0] lane_addr [LANES];
    logic [IDX_W-1:0]  lane_idx  [LANES];
    logic              lane_on   [LANES];
    logic              lane_ok   [LANES];
    logic [ADDR_W-1:0] align_addr;

    assign align_addr = (nbytes == SIZE_W'(1)) ? base_addr
                                               : {base_addr[ADDR_W-1:1], 1'b0};

    function automatic logic in_region(logic [ADDR_W-1:0] a);
        int ai;
        ai = int'(a);
        return (ai < PROM_BYTES) || ((ai >= PMEM_BASE) && (ai < PMEM_END));
    endfunction

    function automatic logic [IDX_W-1:0] to_index(logic [ADDR_W-1:0] a);
        int ai;
        ai = int'(a);
        if (ai < PROM_BYTES)                         return IDX_W'(ai);
        else if ((ai >= PMEM_BASE) && (ai < PMEM_END)) return IDX_W'(PROM_BYTES + ai - PMEM_BASE);
        else                                          return '0;
    endfunction

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_addr[g] = align_addr + ADDR_W'(g);
        assign lane_on[g]   = (SIZE_W'(g) < nbytes);
        assign lane_ok[g]   = in_region(lane_addr[g]);
        assign lane_idx[g]  = to_index(lane_addr[g]);
        assign rdata[g*BYTE_W +: BYTE_W] = !lane_on[g] ? '0 :
                                           (lane_ok[g] ? mem_a[lane_idx[g]] : '1);
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_en && lane_on[l] && lane_ok[l]) begin
                mem_a[lane_idx[l]] <= wdata[l*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
    import rdma_pkg::*;
#(
    parameter int PROM_BYTES = 32,
    parameter int PMEM_BASE  = 256,
    parameter int PMEM_BYTES = 512
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_OFF_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic [BYTE_W-1:0]    reg_rdata,
    input  logic                 dp_rd,
    input  logic                 dp_wr,
    input  logic                 dp_long,
    input  logic [DATA_W-1:0]    dp_wdata,
    output logic [DATA_W-1:0]    dp_rdata,
    input  logic [ADDR_W-1:0]    ring_start,
    input  logic [ADDR_W-1:0]    ring_stop,
    output logic                 dma_done,
    output logic                 irq
);

    logic [BYTE_W-1:0] cmd_q, isr_q, imr_q, dcfg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              take, xfer_done;
    port_req_t         req;

    always_comb begin
        req.fire  = dp_rd || dp_wr;
        req.is_wr = dp_wr;
        req.sz    = pick_size(dp_long, dcfg_q[DCFG_BIT_WIDE]);
    end

    rdma_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cnt_zero  (cnt_q == '0),
        .xfer_done (xfer_done),
        .cmd_q     (cmd_q),
        .isr_q     (isr_q),
        .imr_q     (imr_q),
        .dcfg_q    (dcfg_q),
        .irq       (irq)
    );

    rdma_addr_ctr u_ctr (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .req        (req),
        .ring_start (ring_start),
        .ring_stop  (ring_stop),
        .addr_q     (addr_q),
        .cnt_q      (cnt_q),
        .take       (take),
        .xfer_done  (xfer_done)
    );

    rdma_lane_mem #(
        .PROM_BYTES (PROM_BYTES),
        .PMEM_BASE  (PMEM_BASE),
        .PMEM_BYTES (PMEM_BYTES)
    ) u_mem (
        .clk       (clk),
        .wr_en     (take && req.is_wr),
        .base_addr (addr_q),
        .nbytes    (xfer_bytes(req.sz)),
        .wdata     (dp_wdata),
        .rdata     (dp_rdata)
    );

    always_comb begin
        case (reg_addr)
            OFF_CMD:     reg_rdata = cmd_q;
            OFF_ISR:     reg_rdata = isr_q;
            OFF_ADDR_LO: reg_rdata = addr_q[BYTE_W-1:0];
            OFF_ADDR_HI: reg_rdata = addr_q[ADDR_W-1:BYTE_W];
            OFF_CNT_LO:  reg_rdata = cnt_q[BYTE_W-1:0];
            OFF_CNT_HI:  reg_rdata = cnt_q[CNT_W-1:BYTE_W];
            OFF_DCFG:    reg_rdata = dcfg_q;
            OFF_IMR:     reg_rdata = imr_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign dma_done = isr_q[ISR_BIT_DONE];

    // R3: a four-byte access is only taken when asked for
    p_long_sz_r3: assert property (@(posedge clk) disable iff (rst)
        (req.fire && !dp_long && !dcfg_q[DCFG_BIT_WIDE]) |-> (req.sz == XS_BYTE));

endmodule

// File: tb/rdma_port_engine_tb.sv
module rdma_port_engine_tb_top;
    import rdma_pkg::*;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] OP_W = 3'd0;  // register write
    localparam logic [2:0] OP_P = 3'd1;  // port write
    localparam logic [2:0] OP_R = 3'd2;  // port read, check data
    localparam logic [2:0] OP_C = 3'd3;  // register read check
    localparam logic [2:0] OP_I = 3'd4;  // irq check

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  req;
        logic [3:0]  ra;
        logic        lng;
        logic [31:0] dat;
    } vec_t;

    localparam int NV = 69;
    localparam vec_t TBL [NV] = '{
        '{OP_W, 4'd7,  4'h0, 1'b0, 32'h22},        // R7 go, clears reset bit
        '{OP_C, 4'd7,  4'h7, 1'b0, 32'h00},        // R7
        '{OP_W, 4'd2,  4'h8, 1'b0, 32'h00},        // R2
        '{OP_W, 4'd2,  4'h9, 1'b0, 32'h01},
        '{OP_W, 4'd2,  4'hA, 1'b0, 32'h10},
        '{OP_W, 4'd2,  4'hB, 1'b0, 32'h00},
        '{OP_C, 4'd2,  4'h9, 1'b0, 32'h01},        // R2
        '{OP_W, 4'd2,  4'h8, 1'b0, 32'h04},
        '{OP_C, 4'd2,  4'h8, 1'b0, 32'h04},        // R2 low half
        '{OP_C, 4'd2,  4'h9, 1'b0, 32'h01},        // R2 high half kept
        '{OP_W, 4'd2,  4'h8, 1'b0, 32'h00},
        '{OP_C, 4'd11, 4'hA, 1'b0, 32'h10},        // R11
        '{OP_W, 4'd3,  4'hE, 1'b0, 32'h01},        // R3 two-byte mode
        '{OP_P, 4'd3,  4'h0, 1'b0, 32'h1122},
        '{OP_C, 4'd3,  4'h8, 1'b0, 32'h02},        // R3
        '{OP_C, 4'd3,  4'hA, 1'b0, 32'h0E},        // R3
        '{OP_P, 4'd3,  4'h0, 1'b1, 32'h44332211},
        '{OP_C, 4'd3,  4'h8, 1'b0, 32'h06},        // R3 four bytes
        '{OP_C, 4'd3,  4'hA, 1'b0, 32'h0A},
        '{OP_P, 4'd4,  4'h0, 1'b1, 32'h88776655},
        '{OP_P, 4'd4,  4'h0, 1'b1, 32'hCCBBAA99},
        '{OP_C, 4'd5,  4'h7, 1'b0, 32'h00},        // R5 not done yet
        '{OP_P, 4'd4,  4'h0, 1'b0, 32'hEEDD},
        '{OP_C, 4'd4,  4'h8, 1'b0, 32'h00},        // R4 wrapped
        '{OP_C, 4'd4,  4'h9, 1'b0, 32'h01},        // R4
        '{OP_C, 4'd5,  4'hA, 1'b0, 32'h00},        // R5
        '{OP_C, 4'd5,  4'h7, 1'b0, 32'h40},        // R5 done bit
        '{OP_P, 4'd6,  4'h0, 1'b0, 32'hFFFF},      // R6 ignored
        '{OP_C, 4'd6,  4'h8, 1'b0, 32'h00},        // R6
        '{OP_W, 4'd10, 4'h7, 1'b0, 32'h40},        // R10 clear
        '{OP_C, 4'd10, 4'h7, 1'b0, 32'h00},
        '{OP_W, 4'd7,  4'h0, 1'b0, 32'h0A},        // R7 zero-length read
        '{OP_C, 4'd7,  4'h7, 1'b0, 32'h40},
        '{OP_W, 4'd10, 4'h7, 1'b0, 32'hFF},
        '{OP_C, 4'd10, 4'h7, 1'b0, 32'h00},
        '{OP_W, 4'd5,  4'hA, 1'b0, 32'h08},
        '{OP_R, 4'd6,  4'h0, 1'b0, 32'h00001122},  // R6 memory untouched
        '{OP_R, 4'd9,  4'h0, 1'b1, 32'h44332211},  // R9 byte order
        '{OP_W, 4'd3,  4'hE, 1'b0, 32'h00},        // R3 byte mode
        '{OP_R, 4'd3,  4'h0, 1'b0, 32'h00000055},
        '{OP_C, 4'd5,  4'hA, 1'b0, 32'h01},
        '{OP_R, 4'd5,  4'h0, 1'b0, 32'h00000066},
        '{OP_C, 4'd5,  4'h7, 1'b0, 32'h40},
        '{OP_W, 4'd10, 4'hF, 1'b0, 32'h40},
        '{OP_I, 4'd10, 4'h0, 1'b0, 32'h1},         // R10
        '{OP_W, 4'd10, 4'h7, 1'b0, 32'h40},
        '{OP_I, 4'd10, 4'h0, 1'b0, 32'h0},
        '{OP_W, 4'd10, 4'hF, 1'b0, 32'h00},
        '{OP_W, 4'd9,  4'h8, 1'b0, 32'h03},        // R9 odd address
        '{OP_W, 4'd9,  4'hA, 1'b0, 32'h02},
        '{OP_W, 4'd9,  4'hE, 1'b0, 32'h01},
        '{OP_R, 4'd9,  4'h0, 1'b0, 32'h00002211},
        '{OP_C, 4'd9,  4'h8, 1'b0, 32'h05},
        '{OP_W, 4'd8,  4'hE, 1'b0, 32'h00},        // R8 holes
        '{OP_W, 4'd8,  4'h8, 1'b0, 32'h40},
        '{OP_W, 4'd8,  4'h9, 1'b0, 32'h00},
        '{OP_W, 4'd8,  4'hA, 1'b0, 32'h04},
        '{OP_P, 4'd8,  4'h0, 1'b0, 32'h5A},
        '{OP_W, 4'd8,  4'h8, 1'b0, 32'h40},
        '{OP_R, 4'd8,  4'h0, 1'b0, 32'h000000FF},
        '{OP_W, 4'd8,  4'h8, 1'b0, 32'h05},
        '{OP_P, 4'd8,  4'h0, 1'b0, 32'hA5},
        '{OP_W, 4'd8,  4'h8, 1'b0, 32'h05},
        '{OP_R, 4'd8,  4'h0, 1'b0, 32'h000000A5},
        '{OP_W, 4'd8,  4'h9, 1'b0, 32'h03},
        '{OP_R, 4'd8,  4'h0, 1'b0, 32'h000000FF},
        '{OP_W, 4'd7,  4'h7, 1'b0, 32'hFF},
        '{OP_W, 4'd7,  4'h0, 1'b0, 32'h09},        // R7 halted command
        '{OP_C, 4'd7,  4'h7, 1'b0, 32'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        dp_rd = 1'b0;
    logic        dp_wr = 1'b0;
    logic        dp_long = 1'b0;
    logic [31:0] dp_wdata = '0;
    logic [31:0] dp_rdata;
    logic [15:0] ring_start = 16'h0100;
    logic [15:0] ring_stop  = 16'h0110;
    logic        dma_done;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdma_port_engine dut_i (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_long(dp_long),
        .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
        .ring_start(ring_start), .ring_stop(ring_stop),
        .dma_done(dma_done), .irq(irq)
    );

    task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got 0x%08h expected 0x%08h", rq, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic port_op(input logic wr, input logic lng, input logic [31:0] d,
                           input int rq, input logic [31:0] exp);
        @(negedge clk);
        dp_wr = wr; dp_rd = !wr; dp_long = lng; dp_wdata = d;
        #1;
        if (!wr) check(rq, dp_rdata, exp);
        @(posedge clk); #1;
        dp_wr = 1'b0; dp_rd = 1'b0; dp_long = 1'b0;
    endtask

    task automatic reg_check(input logic [3:0] a, input int rq, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(rq, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    task automatic irq_check(input int rq, input logic exp);
        @(negedge clk); #1;
        check(rq, {31'h0, irq}, {31'h0, exp});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state; R11 readback map
        reg_check(OFF_ISR, 1, 8'h80);
        reg_check(OFF_CMD, 1, 8'h01);
        reg_check(OFF_ADDR_LO, 1, 8'h00);
        reg_check(OFF_CNT_LO, 1, 8'h00);
        reg_check(OFF_DCFG, 1, 8'h00);
        reg_check(4'h3, 11, 8'h00);
        irq_check(1, 1'b0);
        // R10: bit 7 ignores status clears and the 0x7F mask
        reg_write(OFF_ISR, 8'hFF);
        reg_check(OFF_ISR, 10, 8'h80);
        reg_write(OFF_IMR, 8'hFF);
        irq_check(10, 1'b0);
        reg_check(OFF_IMR, 11, 8'hFF);
        reg_write(OFF_IMR, 8'h00);

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                OP_W: reg_write(TBL[i].ra, TBL[i].dat[7:0]);
                OP_P: port_op(1'b1, TBL[i].lng, TBL[i].dat, int'(TBL[i].req), 32'h0);
                OP_R: port_op(1'b0, TBL[i].lng, 32'h0, int'(TBL[i].req), TBL[i].dat);
                OP_C: reg_check(TBL[i].ra, int'(TBL[i].req), TBL[i].dat[7:0]);
                default: irq_check(int'(TBL[i].req), TBL[i].dat[0]);
            endcase
        end

        // R5 dma_done pin follows status bit 6
        reg_write(OFF_CNT_LO, 8'h01);
        port_op(1'b0, 1'b0, 32'h0, 5, 32'h000000FF);
        @(negedge clk); #1;
        check(5, {31'h0, dma_done}, 32'h1);

        // R1 reset from a busy state
        reg_write(OFF_CNT_HI, 8'h12);
        do_reset();
        reg_check(OFF_ISR, 1, 8'h80);
        reg_check(OFF_CNT_HI, 1, 8'h00);
        reg_check(OFF_ADDR_HI, 1, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule